// File: doc/BRIEF.md
# Two-Bank Level-Sensitive Interrupt Controller

This block collects up to 40 level-sensitive interrupt lines and gives a processor core two request outputs: a fast request (FIQ) and a normal request (IRQ). The lines are held in two 32-bit banks. Lines 0 to 31 use bank 0. Lines 32 to 39 use bits 0 to 7 of bank 1. Each bank has a sampled pending word, an enable word and a class word. A class bit of 1 sends its line to the fast output, and a class bit of 0 sends it to the normal output.

Software reaches the block through a 32-bit register bus. The bus uses byte offsets, writes take effect on the clock edge, and reads are combinational. The bus exposes the enable and class words and three views of the pending state: raw, fast-class and normal-class.

The block also holds a wake-override mask. While the core reports that it is halted, this mask decides whether any pending line wakes the core or only enabled ones do. There are 40 source-selection slots. A resolver reads these slots and reports the winning fast source and the winning normal source in one status word.

Top module: `intc_dual_bank`

## Requirements
- R1: Each pending bit stores the level of its input line on every clock edge, with no latching. A line that goes low clears its bit at the next edge. The raw-pending views read the pending words directly: bank 0 at 0x10 and bank 1 at 0xAC.
- R2: Lines 32 to 39 appear in bits 0 to 7 of bank 1. The unused upper bits of the bank-1 pending word read as zero.
- R3: The enable words (0x04 and 0xA0) and the class words (0x08 and 0xA4) are read/write. The normal-pending views (0x00 and 0x9C) read pending & enable & ~class. The fast-pending views (0x0C and 0xA8) read pending & enable & class.
- R4: `fiq_o` is high exactly when, in either bank, some bit of pending & enable & class is set. `irq_o` is high exactly when some bit of pending & enable & ~class is set. A register write shows on both outputs in the cycle after the write edge.
- R5: A write to the control register at 0x14 with data bit 0 = 1 clears the wake-override mask. A write with bit 0 = 0 sets the mask to all ones. A read of 0x14 returns 1 when the mask is zero and 0 otherwise.
- R6: `wake_o` is high only while `halted_i` is high and, in some bank, pending & (enable | wake-override) is nonzero.
- R7: The selection slots are at 0x1C+4k for k = 0..31 and at 0xB0+4(k-32) for k = 32..39. A write keeps only bit 31 (valid) and bits 5:0 (line number). All other bits are stored as zero.
- R8: The status word at 0x18 has this layout: bit 31 is the normal-winner valid flag, bits 21:16 are the normal winner, bit 15 is the fast-winner valid flag, and bits 5:0 are the fast winner. A field with no winner reads 0x3F with its flag clear. A slot counts only if its valid bit is set and its line number is below 40. Among counting slots, the lowest-numbered slot whose line is enabled, pending and of the right class wins.
- R9: Reads of unmapped or misaligned offsets return zero, and writes to them change nothing. Writes to the pending views, the status word and the selection-free offsets are ignored.
- R10: After reset, all pending, enable, class, wake-override and selection state is zero. The outputs are low, the control register reads 1 and the status word reads 0x003F003F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 40 | Interrupt line levels |
| halted_i | input | 1 | Core is halted, so wake logic applies |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
The hardest situation to reach is a status word in which the winning slot is neither the first slot nor a slot that names a valid line. To get there, the stimulus drives lines in both banks and splits their classes across the two outputs. It then points the lowest slot first at a line in bank 1, and later at a line number of 40 or above, so that the next slot must take over. A second case needs both a halted core and a disabled pending line whose wake depends only on the override mask. The bench reaches it by clearing every enable word before it toggles the control register.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [31:0] word_t;

  // byte offsets of the per-bank views, relative to each bank's base
  localparam logic [7:0] OFS_NORM  = 8'h00;
  localparam logic [7:0] OFS_EN    = 8'h04;
  localparam logic [7:0] OFS_CLASS = 8'h08;
  localparam logic [7:0] OFS_FAST  = 8'h0C;
  localparam logic [7:0] OFS_RAW   = 8'h10;

  localparam logic [7:0] BANK0_BASE = 8'h00;
  localparam logic [7:0] BANK1_BASE = 8'h9C;
  localparam logic [7:0] CTRL_ADDR  = 8'h14;
  localparam logic [7:0] WIN_ADDR   = 8'h18;
  localparam logic [7:0] SLOT_LO_BASE = 8'h1C;
  localparam logic [7:0] SLOT_HI_BASE = 8'hB0;
  localparam int         SLOT_LO_CNT  = 32;

  localparam word_t SLOT_KEEP = 32'h8000_003F;
  localparam logic [5:0] NO_WINNER = 6'h3F;

  function automatic logic [7:0] bank_base(input int b);
    return (b == 0) ? BANK0_BASE : BANK1_BASE;
  endfunction

  function automatic word_t fast_view(input word_t pend, input word_t en, input word_t cls);
    return pend & en & cls;
  endfunction

  function automatic word_t norm_view(input word_t pend, input word_t en, input word_t cls);
    return pend & en & ~cls;
  endfunction

  function automatic word_t wake_view(input word_t pend, input word_t en, input word_t ovr);
    return pend & (en | ovr);
  endfunction

  function automatic word_t slot_clean(input word_t v);
    return v & SLOT_KEEP;
  endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIVE   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE-1:0]   src_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_we_i,
  input  logic              cls_we_i,
  input  logic [DATA_W-1:0] ovr_i,
  output logic [DATA_W-1:0] raw_o,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] cls_o,
  output logic [DATA_W-1:0] fastv_o,
  output logic [DATA_W-1:0] normv_o,
  output logic              fast_any_o,
  output logic              norm_any_o,
  output logic              wake_any_o
);
  logic [DATA_W-1:0] src_w;
  logic [DATA_W-1:0] pend_q, en_q, cls_q;

  always_comb begin
    src_w = '0;
    src_w[LIVE-1:0] = src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      cls_q  <= '0;
    end else begin
      pend_q <= src_w;
      if (en_we_i)  en_q  <= wdata_i;
      if (cls_we_i) cls_q <= wdata_i;
    end
  end

  assign raw_o   = pend_q;
  assign en_o    = en_q;
  assign cls_o   = cls_q;
  assign fastv_o = fast_view(pend_q, en_q, cls_q);
  assign normv_o = norm_view(pend_q, en_q, cls_q);

  assign fast_any_o = |fastv_o;
  assign norm_any_o = |normv_o;
  assign wake_any_o = |wake_view(pend_q, en_q, ovr_i);

  // R1
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_o[LIVE-1:0] == $past(src_i)));

  // R2
  pend_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o & ~src_w) == '0 || $past(src_i) != src_i);
endmodule

// File: rtl/intc_slot_file.sv
module intc_slot_file
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  word_t       wdata_i,
  output word_t       slot_o [NUM_SRC]
);
  word_t slot_q [NUM_SRC];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[k] <= '0;
      else if (we_i && idx_i == IDX_W'(k))
        slot_q[k] <= slot_clean(wdata_i);
    end
    assign slot_o[k] = slot_q[k];
  end

  // R7
  slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((slot_o[$past(idx_i)] & ~SLOT_KEEP) == '0));
endmodule

// File: rtl/intc_winner.sv
module intc_winner
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  word_t              slot_i [NUM_SRC],
  input  logic [NUM_SRC-1:0] fast_hot_i,
  input  logic [NUM_SRC-1:0] norm_hot_i,
  output word_t              win_o
);
  logic [63:0] fh, nh;
  logic        f_ok, n_ok;
  logic [5:0]  f_id, n_id;

  always_comb begin
    fh = '0;
    nh = '0;
    fh[NUM_SRC-1:0] = fast_hot_i;
    nh[NUM_SRC-1:0] = norm_hot_i;
    f_ok = 1'b0;
    n_ok = 1'b0;
    f_id = NO_WINNER;
    n_id = NO_WINNER;
    // walk from the last slot down, so the lowest slot overwrites last
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (slot_i[k][31] && (int'(slot_i[k][5:0]) < NUM_SRC)) begin
        if (fh[slot_i[k][5:0]]) begin
          f_ok = 1'b1;
          f_id = slot_i[k][5:0];
        end
        if (nh[slot_i[k][5:0]]) begin
          n_ok = 1'b1;
          n_id = slot_i[k][5:0];
        end
      end
    end
  end

  assign win_o = {n_ok, 9'd0, n_id, f_ok, 9'd0, f_id};

  // R8
  fast_win_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_o[15] |-> fh[win_o[5:0]]);

  // R8
  norm_win_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_o[31] |-> nh[win_o[21:16]]);
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int NUM_BANKS = (NUM_SRC + DATA_W - 1) / DATA_W,
  localparam int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               halted_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               fiq_o,
  output logic               irq_o,
  output logic               wake_o
);
  logic [DATA_W-1:0] raw_b   [NUM_BANKS];
  logic [DATA_W-1:0] en_b    [NUM_BANKS];
  logic [DATA_W-1:0] cls_b   [NUM_BANKS];
  logic [DATA_W-1:0] fastv_b [NUM_BANKS];
  logic [DATA_W-1:0] normv_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] fast_any, norm_any, wake_any, en_we, cls_we;
  logic [NUM_BANKS*DATA_W-1:0] fast_flat, norm_flat, en_flat;

  logic [DATA_W-1:0] ovr_q;
  logic              ctrl_we;
  logic              slot_hit;
  logic [IDX_W-1:0]  slot_idx;
  logic              slot_we;
  logic              any_we;
  word_t             slots [NUM_SRC];
  word_t             win;

  // selection-slot decode
  always_comb begin
    slot_hit = 1'b0;
    slot_idx = '0;
    if (bus_addr_i[1:0] == 2'b00) begin
      if (bus_addr_i >= SLOT_LO_BASE &&
          bus_addr_i < SLOT_LO_BASE + ADDR_W'(4 * SLOT_LO_CNT)) begin
        slot_hit = 1'b1;
        slot_idx = IDX_W'((bus_addr_i - SLOT_LO_BASE) >> 2);
      end else if (bus_addr_i >= SLOT_HI_BASE &&
                   bus_addr_i < SLOT_HI_BASE + ADDR_W'(4 * (NUM_SRC - SLOT_LO_CNT))) begin
        slot_hit = 1'b1;
        slot_idx = IDX_W'(SLOT_LO_CNT + int'((bus_addr_i - SLOT_HI_BASE) >> 2));
      end
    end
  end

  assign slot_we = bus_wr_i && slot_hit;
  assign ctrl_we = bus_wr_i && (bus_addr_i == CTRL_ADDR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int REST = NUM_SRC - b * DATA_W;
    localparam int LIVE = (REST > DATA_W) ? DATA_W : REST;

    assign en_we[b]  = bus_wr_i && (bus_addr_i == bank_base(b) + OFS_EN);
    assign cls_we[b] = bus_wr_i && (bus_addr_i == bank_base(b) + OFS_CLASS);

    intc_bank #(.DATA_W(DATA_W), .LIVE(LIVE)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[b*DATA_W +: LIVE]),
      .wdata_i   (bus_wdata_i),
      .en_we_i   (en_we[b]),
      .cls_we_i  (cls_we[b]),
      .ovr_i     (ovr_q),
      .raw_o     (raw_b[b]),
      .en_o      (en_b[b]),
      .cls_o     (cls_b[b]),
      .fastv_o   (fastv_b[b]),
      .normv_o   (normv_b[b]),
      .fast_any_o(fast_any[b]),
      .norm_any_o(norm_any[b]),
      .wake_any_o(wake_any[b])
    );

    assign fast_flat[b*DATA_W +: DATA_W] = fastv_b[b];
    assign norm_flat[b*DATA_W +: DATA_W] = normv_b[b];
    assign en_flat[b*DATA_W +: DATA_W]   = en_b[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_q <= '0;
    else if (ctrl_we)
      ovr_q <= bus_wdata_i[0] ? '0 : '1;
  end

  intc_slot_file #(.NUM_SRC(NUM_SRC)) u_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (slot_we),
    .idx_i  (slot_idx),
    .wdata_i(bus_wdata_i),
    .slot_o (slots)
  );

  intc_winner #(.NUM_SRC(NUM_SRC)) u_winner (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_i    (slots),
    .fast_hot_i(fast_flat[NUM_SRC-1:0]),
    .norm_hot_i(norm_flat[NUM_SRC-1:0]),
    .win_o     (win)
  );

  assign fiq_o  = |fast_any;
  assign irq_o  = |norm_any;
  assign wake_o = halted_i && (|wake_any);

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr_i == bank_base(b) + OFS_NORM)  bus_rdata_o = normv_b[b];
      if (bus_addr_i == bank_base(b) + OFS_EN)    bus_rdata_o = en_b[b];
      if (bus_addr_i == bank_base(b) + OFS_CLASS) bus_rdata_o = cls_b[b];
      if (bus_addr_i == bank_base(b) + OFS_FAST)  bus_rdata_o = fastv_b[b];
      if (bus_addr_i == bank_base(b) + OFS_RAW)   bus_rdata_o = raw_b[b];
    end
    if (bus_addr_i == CTRL_ADDR) bus_rdata_o = DATA_W'(ovr_q == '0);
    if (bus_addr_i == WIN_ADDR)  bus_rdata_o = win;
    if (slot_hit)                bus_rdata_o = slots[slot_idx];
  end

  assign any_we = (|en_we) || (|cls_we) || ctrl_we || slot_we;

  // R4
  fiq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (|fast_flat));

  // R4
  irq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|norm_flat));

  // R6
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_i |-> !wake_o);

  // R5
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && bus_wdata_i[0]) |=> (ovr_q == '0));

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !bus_wdata_i[0]) |=> (ovr_q == '1));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !any_we) |=> ($stable(ovr_q) && $stable(en_flat)));
endmodule

// File: tb/intc_dual_bank_test.sv
`timescale 1ns/1ps
module intc_dual_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src = '0;
  logic        halted = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq, wake;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  intc_dual_bank uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .halted_i(halted),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_src(input logic [39:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(8'h04, d); check("R10 enable0 reset", d, 32'h0);
    rd_reg(8'hA4, d); check("R10 class1 reset", d, 32'h0);
    rd_reg(8'h14, d); check("R10 control reset", d, 32'h1);
    rd_reg(8'h18, d); check("R10 status reset", d, 32'h003F_003F);
    rd_reg(8'h1C, d); check("R10 slot0 reset", d, 32'h0);
    check("R10 outputs low", {29'd0, fiq, irq, wake}, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    drive_src(40'h08_0000_0008);  // lines 3 and 35
    rd_reg(8'h10, d); check("R1 raw bank0", d, 32'h8);
    rd_reg(8'hAC, d); check("R2 raw bank1 line35->bit3", d, 32'h8);
    drive_src(40'h08_0000_0000);
    rd_reg(8'h10, d); check("R1 raw bank0 cleared on low", d, 32'h0);
    drive_src(40'hFF_0000_0000);
    rd_reg(8'hAC, d); check("R2 bank1 upper bits zero", d, 32'hFF);
  endtask

  task automatic t_steer();
    logic [31:0] d;
    drive_src(40'h08_0000_0028);  // lines 3, 5, 35
    wr_reg(8'h04, 32'h28);
    wr_reg(8'h08, 32'h20);
    wr_reg(8'hA0, 32'h08);
    wr_reg(8'hA4, 32'h00);
    rd_reg(8'h00, d); check("R3 normal view bank0", d, 32'h08);
    rd_reg(8'h0C, d); check("R3 fast view bank0", d, 32'h20);
    rd_reg(8'h9C, d); check("R3 normal view bank1", d, 32'h08);
    rd_reg(8'hA8, d); check("R3 fast view bank1", d, 32'h00);
    check("R4 both requests", {30'd0, fiq, irq}, 32'h3);
    wr_reg(8'h08, 32'h28);
    rd_reg(8'h08, d); check("R3 class0 readback", d, 32'h28);
    rd_reg(8'h00, d); check("R3 normal view bank0 empty", d, 32'h0);
    check("R4 irq held by bank1", {31'd0, irq}, 32'h1);
    wr_reg(8'hA0, 32'h0);
    check("R4 irq drops next cycle", {31'd0, irq}, 32'h0);
    check("R4 fiq stays", {31'd0, fiq}, 32'h1);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr_reg(8'h04, 32'h0);
    @(negedge clk); halted = 1'b1;
    #1 check("R6 halted, nothing enabled", {31'd0, wake}, 32'h0);
    check("R4 no request without enables", {30'd0, fiq, irq}, 32'h0);
    wr_reg(8'h14, 32'h0);
    check("R6 override wakes disabled pending", {31'd0, wake}, 32'h1);
    rd_reg(8'h14, d); check("R5 control reads 0 with mask set", d, 32'h0);
    @(negedge clk); halted = 1'b0;
    #1 check("R6 not halted gives no wake", {31'd0, wake}, 32'h0);
    @(negedge clk); halted = 1'b1;
    wr_reg(8'h14, 32'h1);
    check("R6 override cleared", {31'd0, wake}, 32'h0);
    rd_reg(8'h14, d); check("R5 control reads 1 after clear", d, 32'h1);
    wr_reg(8'hA0, 32'h08);
    check("R6 enabled pending wakes", {31'd0, wake}, 32'h1);
    @(negedge clk); halted = 1'b0;
    wr_reg(8'hA0, 32'h0);
  endtask

  task automatic t_slots();
    logic [31:0] d;
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    rd_reg(8'h1C, d); check("R7 slot0 keeps valid and id", d, 32'h8000_003F);
    wr_reg(8'hCC, 32'h1234_5678);
    rd_reg(8'hCC, d); check("R7 slot39 masked", d, 32'h0000_0038);
    wr_reg(8'h98, 32'h8000_0011);
    rd_reg(8'h98, d); check("R7 slot31 at top of low range", d, 32'h8000_0011);
  endtask

  task automatic t_winner();
    logic [31:0] d;
    drive_src(40'h08_0000_0028);
    wr_reg(8'h04, 32'h28);
    wr_reg(8'h08, 32'h20);
    wr_reg(8'hA0, 32'h08);
    wr_reg(8'hA4, 32'h00);
    wr_reg(8'h1C, 32'h8000_0023);  // slot0 -> line 35
    wr_reg(8'h20, 32'h8000_0003);  // slot1 -> line 3
    wr_reg(8'h24, 32'h8000_0005);  // slot2 -> line 5
    rd_reg(8'h18, d); check("R8 lowest slot wins, bank1 line", d, 32'h8023_8005);
    wr_reg(8'h1C, 32'h8000_002D);  // line 45: not a real line
    rd_reg(8'h18, d); check("R8 out-of-range line skipped", d, 32'h8003_8005);
    wr_reg(8'h20, 32'h0000_0003);  // valid bit clear
    rd_reg(8'h18, d); check("R8 invalid slot skipped", d, 32'h003F_8005);
    wr_reg(8'h04, 32'h0);
    wr_reg(8'hA0, 32'h0);
    rd_reg(8'h18, d); check("R8 no winners", d, 32'h003F_003F);
  endtask

  task automatic t_stray();
    logic [31:0] d;
    wr_reg(8'hD0, 32'hFFFF_FFFF);
    rd_reg(8'hD0, d); check("R9 unmapped read zero", d, 32'h0);
    rd_reg(8'h04, d); check("R9 unmapped write leaves enable", d, 32'h0);
    rd_reg(8'h14, d); check("R9 unmapped write leaves control", d, 32'h1);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h10, d); check("R9 raw view read-only", d, 32'h28);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h04, d); check("R9 normal view write ignored", d, 32'h0);
    wr_reg(8'h18, 32'h0);
    rd_reg(8'h18, d); check("R9 status write ignored", d, 32'h003F_003F);
    rd_reg(8'h06, d); check("R9 misaligned read zero", d, 32'h0);
    wr_reg(8'h1E, 32'h8000_0001);
    rd_reg(8'h1C, d); check("R9 misaligned slot write ignored", d, 32'h8000_002D);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_levels();
    t_steer();
    t_wake();
    t_slots();
    t_winner();
    t_stray();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule